// File: doc/BRIEF.md
# Test Output Selector with Bypass Dividers

This block drives a clock synthesizer's single test pin and its main divided clock output. A three-bit test code chooses which internal signal appears on the test pin: the serial shift-register output, a constant level, the reference clock, the feedback M counter pulse, the main output clock, or that clock divided by four. One code puts the block in PLL bypass. The slow serial configuration clock then replaces the VCO as the source of both dividers. The N divider drives the main output and the M counter drives the test pin, so a board can step its clock tree by hand.

The block runs on one fast system clock. Each source clock arrives as a one-cycle advance strobe: `vco_tick` for the VCO and `sclk_tick` for the serial clock. A tick stands for one full period of that source. The test code passes through a select register that the active-low parallel-load control holds at code 000. Whenever the effective code changes, both dividers restart from zero, so a mode switch leaves no partial period on either output. The block has no streaming data path. All pins are plain control and clock-level signals with no handshake.

Top module: `testsel_bypass`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `test_out` and `fout` are both 0.
- R2: The effective code is `test_code` when `pload_n` is high and 000 when `pload_n` is low. It is registered once, so a code applied before a clock edge governs the next edge.
- R3: `test_out` is registered from the currently selected code. 000 gives `sr_out`, 001 gives 1, 010 gives `fref` and 101 gives 0, each one cycle after the input is sampled.
- R4: The N divider counts source ticks. `n_code` 00, 01 and 10 give ratios 2, 4 and 8: `fout` toggles after every 1, 2 and 4 ticks, a 50% duty square wave. `n_code` 11 gives ratio 1: `fout` is high for exactly the one cycle after each tick.
- R5: The M counter emits a one-cycle high pulse on the tick that completes `m_val` ticks, then starts over. An `m_val` of 0 counts 512 ticks. Code 011 shows this pulse on `test_out`.
- R6: Under code 110 (bypass), both dividers count `sclk_tick` and ignore `vco_tick`, and `test_out` shows the M counter pulse.
- R7: Under every code other than 110, both dividers count `vco_tick`, and `sclk_tick` has no effect on either output.
- R8: Code 100 shows `fout` on `test_out`. Code 111 shows a divide-by-4 of `fout`: its level flips on every second rising edge of `fout`, counted from the last restart.
- R9: On the clock edge where the effective code changes, the N and M counters, `fout`, the M pulse and the divide-by-4 state all clear to zero, and any tick in that cycle is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pload_n | input | 1 | Parallel load control; low forces test code 000 |
| test_code | input | 3 | Test field from the configuration register |
| n_code | input | 2 | Output divider ratio code |
| m_val | input | 9 | M counter terminal count (0 means 512) |
| fref | input | 1 | Reference clock level |
| vco_tick | input | 1 | One-cycle strobe per VCO period |
| sclk_tick | input | 1 | One-cycle strobe per serial clock period |
| sr_out | input | 1 | Serial shift-register output |
| test_out | output | 1 | Test pin |
| fout | output | 1 | Main divided clock output |

## Verification
Two functions can act on the same edge. A change of the effective code restarts the dividers while a source tick would otherwise advance them. The bench provokes this by switching `test_code` and pulsing `pload_n` at random, with ticks arriving on most cycles. A cycle-level reference computed in the bench drops the tick on a restart edge. The bench compares `fout` and `test_out` with that reference on every cycle, including the first edges after a mode change.

// File: rtl/testsel_pkg.sv
package testsel_pkg;
  typedef enum logic [2:0] {
    SEL_SHIFT  = 3'b000,
    SEL_HIGH   = 3'b001,
    SEL_REF    = 3'b010,
    SEL_MPULSE = 3'b011,
    SEL_FOUT   = 3'b100,
    SEL_LOW    = 3'b101,
    SEL_BYPASS = 3'b110,
    SEL_FDIV4  = 3'b111
  } sel_e;
endpackage

// File: rtl/tsel_latch.sv
module tsel_latch #(
  parameter int TW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pload_n,
  input  logic [TW-1:0] test_code,
  output logic [TW-1:0] sel_o,
  output logic          restart_o
);
  logic [TW-1:0] sel_d, sel_q;

  always_comb begin
    sel_d     = pload_n ? test_code : '0;
    restart_o = (sel_d != sel_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= '0;
    else        sel_q <= sel_d;
  end

  assign sel_o = sel_q;

  // R2: a low load control leaves the select at 000 on the next edge
  a_r2_pload_forces: assert property (@(posedge clk) disable iff (!rst_n)
    !pload_n |=> (sel_q == '0));
endmodule

// File: rtl/tsel_ndiv.sv
module tsel_ndiv #(
  parameter int NW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          tick,
  input  logic [NW-1:0] n_code,
  output logic          fout_o
);
  localparam int HCW = 2**NW;
  logic [HCW-1:0] cnt_q, half_m1;
  logic           fout_q, unity;

  always_comb begin
    unity   = &n_code;
    half_m1 = (HCW'(1) << n_code) - HCW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      fout_q <= 1'b0;
    end else if (restart) begin
      cnt_q  <= '0;
      fout_q <= 1'b0;
    end else if (unity) begin
      cnt_q  <= '0;
      fout_q <= tick;
    end else if (tick) begin
      if (cnt_q >= half_m1) begin
        cnt_q  <= '0;
        fout_q <= ~fout_q;
      end else begin
        cnt_q <= cnt_q + HCW'(1);
      end
    end
  end

  assign fout_o = fout_q;

  // R4: with a square-wave ratio, fout never moves without a tick
  a_r4_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && !tick && !unity) |=> $stable(fout_q));
  // R9: a restart leaves the output low
  a_r9_ndiv_clear: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !fout_q);
endmodule

// File: rtl/tsel_mcnt.sv
module tsel_mcnt #(
  parameter int MW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          tick,
  input  logic [MW-1:0] m_val,
  output logic          pulse_o
);
  localparam int CW = MW + 1;
  logic [CW-1:0] cnt_q, term_m1;
  logic          pulse_q;

  always_comb begin
    if (m_val == '0) term_m1 = CW'((2**MW) - 1);
    else             term_m1 = {1'b0, m_val} - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else if (restart) begin
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else if (tick) begin
      if (cnt_q >= term_m1) begin
        cnt_q   <= '0;
        pulse_q <= 1'b1;
      end else begin
        cnt_q   <= cnt_q + CW'(1);
        pulse_q <= 1'b0;
      end
    end else begin
      pulse_q <= 1'b0;
    end
  end

  assign pulse_o = pulse_q;

  // R5: with a count above one, a pulse lasts a single cycle
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_q && (m_val > MW'(1))) |=> !pulse_q);
  // R9: a restart clears the counter and the pulse
  a_r9_mcnt_clear: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> ((cnt_q == '0) && !pulse_q));
endmodule

// File: rtl/tsel_outmux.sv
module tsel_outmux
  import testsel_pkg::*;
#(
  parameter int TW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic [TW-1:0] sel,
  input  logic          sr_out,
  input  logic          fref,
  input  logic          mpulse,
  input  logic          fout,
  output logic          test_o
);
  logic       fprev_q, test_q, pick;
  logic [1:0] rise_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fprev_q <= 1'b0;
      rise_q  <= '0;
    end else if (restart) begin
      fprev_q <= 1'b0;
      rise_q  <= '0;
    end else begin
      fprev_q <= fout;
      if (fout && !fprev_q) rise_q <= rise_q + 2'd1;
    end
  end

  always_comb begin
    unique case (sel_e'(sel))
      SEL_SHIFT:  pick = sr_out;
      SEL_HIGH:   pick = 1'b1;
      SEL_REF:    pick = fref;
      SEL_MPULSE: pick = mpulse;
      SEL_FOUT:   pick = fout;
      SEL_LOW:    pick = 1'b0;
      SEL_BYPASS: pick = mpulse;
      SEL_FDIV4:  pick = rise_q[1];
      default:    pick = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) test_q <= 1'b0;
    else        test_q <= pick;
  end

  assign test_o = test_q;

  // R3: constant-high code drives the pin high one edge later
  a_r3_const_high: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == TW'(3'b001)) |=> test_q);
  // R3: constant-low code drives the pin low one edge later
  a_r3_const_low: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == TW'(3'b101)) |=> !test_q);
endmodule

// File: rtl/testsel_bypass.sv
module testsel_bypass
  import testsel_pkg::*;
#(
  parameter int TW = 3,
  parameter int NW = 2,
  parameter int MW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pload_n,
  input  logic [TW-1:0] test_code,
  input  logic [NW-1:0] n_code,
  input  logic [MW-1:0] m_val,
  input  logic          fref,
  input  logic          vco_tick,
  input  logic          sclk_tick,
  input  logic          sr_out,
  output logic          test_out,
  output logic          fout
);
  logic [TW-1:0] sel;
  logic          restart, src_tick, mpulse, fout_w;

  tsel_latch #(.TW(TW)) u_latch (
    .clk(clk), .rst_n(rst_n), .pload_n(pload_n), .test_code(test_code),
    .sel_o(sel), .restart_o(restart)
  );

  assign src_tick = (sel == TW'(SEL_BYPASS)) ? sclk_tick : vco_tick;

  tsel_ndiv #(.NW(NW)) u_ndiv (
    .clk(clk), .rst_n(rst_n), .restart(restart), .tick(src_tick),
    .n_code(n_code), .fout_o(fout_w)
  );

  tsel_mcnt #(.MW(MW)) u_mcnt (
    .clk(clk), .rst_n(rst_n), .restart(restart), .tick(src_tick),
    .m_val(m_val), .pulse_o(mpulse)
  );

  tsel_outmux #(.TW(TW)) u_mux (
    .clk(clk), .rst_n(rst_n), .restart(restart), .sel(sel),
    .sr_out(sr_out), .fref(fref), .mpulse(mpulse), .fout(fout_w),
    .test_o(test_out)
  );

  assign fout = fout_w;

  // R6: in bypass with no serial tick and no restart, fout holds for square-wave ratios
  a_r6_bypass_ignores_vco: assert property (@(posedge clk) disable iff (!rst_n)
    ((sel == TW'(SEL_BYPASS)) && !restart && !sclk_tick && !(&n_code)) |=> $stable(fout));
endmodule

// File: tb/testsel_bypass_tb.sv
module testsel_bypass_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pload_n = 1'b1;
  logic [2:0] test_code = '0;
  logic [1:0] n_code = '0;
  logic [8:0] m_val = 9'd3;
  logic fref = 0, vco_tick = 0, sclk_tick = 0, sr_out = 0;
  logic test_out, fout;

  int tests = 0, fails = 0, cycles = 0;
  bit done = 0;

  // reference state
  int  s_sel = 0, s_ncnt = 0, s_mcnt = 0, s_r = 0;
  bit  s_fout = 0, s_mp = 0, s_fprev = 0, s_test = 0;

  always #4 clk = ~clk;

  testsel_bypass dut_i (
    .clk(clk), .rst_n(rst_n), .pload_n(pload_n), .test_code(test_code),
    .n_code(n_code), .m_val(m_val), .fref(fref), .vco_tick(vco_tick),
    .sclk_tick(sclk_tick), .sr_out(sr_out), .test_out(test_out), .fout(fout)
  );

  function automatic int half_of(input int n);
    return 1 << n;
  endfunction

  function automatic int term_of(input int m);
    return (m == 0) ? 512 : m;
  endfunction

  function automatic bit mux_ref(input int sel, input bit sr, input bit fr,
                                 input bit mp, input bit fo, input int r);
    case (sel)
      0: return sr;
      1: return 1'b1;
      2: return fr;
      3: return mp;
      4: return fo;
      5: return 1'b0;
      6: return mp;
      default: return r[1];
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst_n) begin
      int eff, tk; bit rs, nt;
      eff = pload_n ? int'(test_code) : 0;
      rs  = (eff != s_sel);
      tk  = (s_sel == 6) ? int'(sclk_tick) : int'(vco_tick);
      nt  = mux_ref(s_sel, sr_out, fref, s_mp, s_fout, s_r);
      if (rs) begin
        s_ncnt = 0; s_fout = 0; s_mcnt = 0; s_mp = 0; s_fprev = 0; s_r = 0;
      end else begin
        if (s_fout && !s_fprev) s_r = (s_r + 1) % 4;
        s_fprev = s_fout;
        if (n_code == 2'b11) begin
          s_ncnt = 0; s_fout = bit'(tk);
        end else if (tk != 0) begin
          if (s_ncnt >= half_of(int'(n_code)) - 1) begin s_ncnt = 0; s_fout = !s_fout; end
          else s_ncnt++;
        end
        if (tk != 0) begin
          if (s_mcnt >= term_of(int'(m_val)) - 1) begin s_mcnt = 0; s_mp = 1; end
          else begin s_mcnt++; s_mp = 0; end
        end else s_mp = 0;
      end
      s_test = nt;
      s_sel  = eff;
    end
  end

  task automatic check(input string req, input bit act, input bit exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0b expected %0b (cycle %0d)", req, act, exp, cycles);
    end
  endtask

  function automatic string fout_req();
    if (s_sel == 6) return "R6";
    return (n_code == 2'b11) ? "R4" : "R7";
  endfunction

  function automatic string test_req();
    case (s_sel)
      0: return pload_n ? "R3" : "R2";
      3: return "R5";
      6: return "R6";
      4, 7: return "R8";
      default: return "R3";
    endcase
  endfunction

  // one cycle: check at negedge, then drive new inputs
  task automatic step(input int tickpct, input int sclkpct);
    @(negedge clk);
    cycles++;
    check(fout_req(), fout, s_fout);
    check(test_req(), test_out, s_test);
    vco_tick  = ($urandom % 100) < tickpct;
    sclk_tick = ($urandom % 100) < sclkpct;
    fref      = $urandom % 2;
    sr_out    = $urandom % 2;
  endtask

  initial begin
    int seed;
    seed = $urandom(32'd2024);
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1", test_out, 1'b0);
    check("R1", fout, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", test_out, 1'b0);
    check("R1", fout, 1'b0);

    // each code with each ratio, random ticks (R3 R4 R5 R7 R8)
    for (int c = 0; c < 8; c++) begin
      for (int n = 0; n < 4; n++) begin
        test_code = 3'(c); n_code = 2'(n); m_val = 9'(1 + $urandom % 12);
        for (int k = 0; k < 120; k++) step(70, 50);
      end
    end
    // R9: rapid code switching, restart collides with ticks
    for (int k = 0; k < 1500; k++) begin
      if ($urandom % 8 == 0) test_code = 3'($urandom % 8);
      if ($urandom % 16 == 0) n_code = 2'($urandom % 4);
      pload_n = ($urandom % 10) != 0;
      step(90, 90);
    end
    pload_n = 1'b1;
    // R2: held load control shows shift output whatever the code
    test_code = 3'b001;
    pload_n = 1'b0;
    for (int k = 0; k < 60; k++) step(50, 50);
    pload_n = 1'b1;
    // R6: bypass with serial ticks only, then VCO ticks only
    test_code = 3'b110; n_code = 2'b01; m_val = 9'd5;
    for (int k = 0; k < 200; k++) step(0, 60);
    for (int k = 0; k < 100; k++) step(100, 0);
    // R7: serial ticks ignored outside bypass
    test_code = 3'b100;
    for (int k = 0; k < 100; k++) step(0, 100);
    // R5: m_val 0 counts 512 ticks
    test_code = 3'b011; m_val = 9'd0;
    for (int k = 0; k < 1100; k++) step(100, 0);
    // R5: m_val 1 pulses every tick
    m_val = 9'd1;
    for (int k = 0; k < 50; k++) step(100, 0);
    // R8 long divide-by-4 run
    test_code = 3'b111; n_code = 2'b00;
    for (int k = 0; k < 200; k++) step(100, 0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule